// File: doc/BRIEF.md
# BCD Real-Time Clock Core

This core keeps calendar time: seconds, minutes, hours, day of month, month, a two-digit year and a weekday. Every value is held as packed BCD, one decimal digit per 4-bit register. A host sees the core as sixteen 4-bit registers behind a synchronous port. A write takes effect at the clock edge on which `wr_en_i` is high. A read is combinational from `addr_i`. The 1 Hz and 64 Hz tick enables come from a prescaler outside the core, and each lasts one clock cycle.

The time digits sit at indices 0 to 12. The three control registers sit at indices 13 to 15. They provide a freeze handshake for safe access, a rounding adjust to the nearest minute, an interrupt line, a counting stop, and a seconds reset. The interrupt line has a selectable period and runs either as a level or as a short pulse. The seconds reset is also the only moment at which the 12/24-hour choice is latched.

Top module: `rtc_bcd_core`

## Requirements
- R1: After `rst_n` is released, the core reads as 00:00:00, day 01, month 01, year 00, weekday 0. Index 13 reads 0, index 14 reads 1 (output masked, pulse style, 64 Hz period), index 15 reads 4 (24-hour mode), and `irq_o` is low.
- R2: Each 1 Hz tick advances the seconds by one. The register map is: index 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 day units, 7 day tens, 8 month units, 9 month tens, 10 year units, 11 year tens, 12 weekday. Seconds 59 wrap to 00 and carry into minutes, and minutes 59 wrap to 00 and carry into hours.
- R3: In 24-hour mode, hour 23 wraps to 00 and advances the day. The weekday (0 = Sunday) advances with every day and wraps from 6 to 0.
- R4: Days wrap at the month length: 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for February when the year value is a multiple of 4 (28 otherwise). The day then restarts at 01, and the month advances. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: In 12-hour mode, hours run 1 to 12. Bit 2 of index 5 is the PM flag and bit 0 is the tens digit. 11 becomes 12 and toggles PM, 12 becomes 1, and 11 PM becomes 12 AM with a day advance.
- R6: Index 13 bit 0 is the freeze flag. While it is 1, ticks leave the time unchanged. One tick that arrives during the freeze is applied in the first cycle after the flag clears. Index 13 bit 1 reads 1 exactly in a cycle in which the time advances.
- R7: Writing index 13 with bit 3 set rounds the time. Seconds of 30 or more clear the seconds and add one minute with full carry. Lower seconds only clear. Bit 3 always reads 0.
- R8: Index 13 bit 2 is the pending flag. It sets on each event of the period in index 14 bits 3:2 (0 = 64 Hz tick, 1 = second, 2 = minute wrap, 3 = hour wrap). A write to index 13 with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged.
- R9: With index 14 bit 1 = 1 (level style) and bit 0 = 0, `irq_o` equals the pending flag.
- R10: With index 14 bit 1 = 0 (pulse style), `irq_o` rises in the cycle after a period event and falls after the next 64 Hz tick.
- R11: Index 14 bit 0 = 1 holds `irq_o` low in both styles, without changing the pending flag.
- R12: Index 15 bit 1 = 1 stops counting. Ticks received while stopped are discarded.
- R13: While index 15 bit 0 is 1, the seconds digits read 00, counting is held, and a deferred tick is dropped. The other registers keep their values. The mode selected by index 15 bit 2 (1 = 24-hour) is adopted only while bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz_i | input | 1 | One-cycle enable, once per second |
| tick_64hz_i | input | 1 | One-cycle enable, 64 times per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index for read and write |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt or pulse output |

## Verification
The hardest state to reach from the ports is the deferred tick. A tick must land while the freeze flag is set, and the release must then be observed in the very cycle it takes effect, because the busy bit is visible for one cycle only. The stimulus sets the freeze flag, fires a tick, reads the frozen seconds, clears the flag, and reads index 13 in the cycle right after the write. Day, month and year carries are reached quickly by loading 23:59:59 on chosen dates and firing one tick. The 12/24-hour latch is checked with the reset bit both clear and set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DIG_W = 4;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IX_SEC_U  = 4'd0;
    localparam logic [IDX_W-1:0] IX_SEC_T  = 4'd1;
    localparam logic [IDX_W-1:0] IX_MIN_U  = 4'd2;
    localparam logic [IDX_W-1:0] IX_MIN_T  = 4'd3;
    localparam logic [IDX_W-1:0] IX_HR_U   = 4'd4;
    localparam logic [IDX_W-1:0] IX_HR_T   = 4'd5;
    localparam logic [IDX_W-1:0] IX_DAY_U  = 4'd6;
    localparam logic [IDX_W-1:0] IX_DAY_T  = 4'd7;
    localparam logic [IDX_W-1:0] IX_MON_U  = 4'd8;
    localparam logic [IDX_W-1:0] IX_MON_T  = 4'd9;
    localparam logic [IDX_W-1:0] IX_YR_U   = 4'd10;
    localparam logic [IDX_W-1:0] IX_YR_T   = 4'd11;
    localparam logic [IDX_W-1:0] IX_WDAY   = 4'd12;
    localparam logic [IDX_W-1:0] IX_SYNC   = 4'd13;
    localparam logic [IDX_W-1:0] IX_OUTCTL = 4'd14;
    localparam logic [IDX_W-1:0] IX_RUNCTL = 4'd15;

    typedef struct packed {
        logic [DIG_W-1:0] su, st, mu, mt, hu, ht, du, dt, mou, mot, yu, yt, wd;
    } rtc_time_t;

    typedef enum logic [1:0] {
        PER_TICK64 = 2'd0,
        PER_SECOND = 2'd1,
        PER_MINUTE = 2'd2,
        PER_HOUR   = 2'd3
    } rtc_period_e;

    function automatic logic [7:0] bcd_to_bin(input logic [DIG_W-1:0] t, input logic [DIG_W-1:0] u);
        return ({4'd0, t} * 8'd10) + {4'd0, u};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
        logic [7:0] q;
        logic [7:0] r;
        q = v / 8'd10;
        r = v - (q * 8'd10);
        return {q[3:0], r[3:0]};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t tm_i,
    input  logic      h24_i,
    output rtc_time_t tm_o,
    output logic      sec_wrap_o,
    output logic      min_wrap_o
);
    logic [7:0] s_b, m_b, h_b, d_b, mo_b, y_b, len_b;
    logic [7:0] nh_b, bcd_tmp;
    logic       hr_wrap, day_wrap, mon_wrap, pm_n;

    always_comb begin
        tm_o     = tm_i;
        hr_wrap  = 1'b0;
        day_wrap = 1'b0;
        mon_wrap = 1'b0;
        pm_n     = tm_i.ht[2];
        nh_b     = 8'd0;
        s_b  = bcd_to_bin(tm_i.st, tm_i.su);
        m_b  = bcd_to_bin(tm_i.mt, tm_i.mu);
        d_b  = bcd_to_bin(tm_i.dt, tm_i.du);
        mo_b = bcd_to_bin(tm_i.mot, tm_i.mou);
        y_b  = bcd_to_bin(tm_i.yt, tm_i.yu);
        len_b = month_len(mo_b, y_b);
        h_b  = h24_i ? bcd_to_bin(tm_i.ht, tm_i.hu)
                     : bcd_to_bin({3'b000, tm_i.ht[0]}, tm_i.hu);

        // seconds
        sec_wrap_o = (s_b >= 8'd59);
        bcd_tmp = bin_to_bcd(sec_wrap_o ? 8'd0 : s_b + 8'd1);
        {tm_o.st, tm_o.su} = bcd_tmp;

        // minutes
        min_wrap_o = sec_wrap_o && (m_b >= 8'd59);
        if (sec_wrap_o) begin
            bcd_tmp = bin_to_bcd(min_wrap_o ? 8'd0 : m_b + 8'd1);
            {tm_o.mt, tm_o.mu} = bcd_tmp;
        end

        // hours
        if (min_wrap_o) begin
            if (h24_i) begin
                hr_wrap = (h_b >= 8'd23);
                nh_b    = hr_wrap ? 8'd0 : h_b + 8'd1;
                bcd_tmp = bin_to_bcd(nh_b);
                tm_o.ht = bcd_tmp[7:4];
                tm_o.hu = bcd_tmp[3:0];
            end else begin
                if (h_b == 8'd11) begin
                    nh_b    = 8'd12;
                    pm_n    = ~tm_i.ht[2];
                    hr_wrap = tm_i.ht[2];
                end else if (h_b >= 8'd12) begin
                    nh_b = 8'd1;
                end else begin
                    nh_b = h_b + 8'd1;
                end
                bcd_tmp = bin_to_bcd(nh_b);
                tm_o.ht = {1'b0, pm_n, 1'b0, bcd_tmp[4]};
                tm_o.hu = bcd_tmp[3:0];
            end
        end

        // day, weekday, month, year
        if (hr_wrap) begin
            tm_o.wd  = (tm_i.wd >= 4'd6) ? 4'd0 : tm_i.wd + 4'd1;
            day_wrap = (d_b >= len_b);
            bcd_tmp  = bin_to_bcd(day_wrap ? 8'd1 : d_b + 8'd1);
            {tm_o.dt, tm_o.du} = bcd_tmp;
        end
        if (day_wrap) begin
            mon_wrap = (mo_b >= 8'd12);
            bcd_tmp  = bin_to_bcd(mon_wrap ? 8'd1 : mo_b + 8'd1);
            {tm_o.mot, tm_o.mou} = bcd_tmp;
        end
        if (mon_wrap) begin
            bcd_tmp = bin_to_bcd((y_b >= 8'd99) ? 8'd0 : y_b + 8'd1);
            {tm_o.yt, tm_o.yu} = bcd_tmp;
        end
    end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick64_i,
    input  logic        run_i,
    input  logic        sec_evt_i,
    input  logic        min_evt_i,
    input  logic        hour_evt_i,
    input  rtc_period_e period_i,
    input  logic        level_i,
    input  logic        mask_i,
    input  logic        clr_i,
    input  logic        quiet_i,
    output logic        pend_o,
    output logic        irq_o
);
    typedef struct packed {
        logic pend;
        logic pulse;
    } irq_state_t;

    irq_state_t st_q, st_d;
    logic       evt;

    always_comb begin
        case (period_i)
            PER_TICK64: evt = tick64_i && run_i;
            PER_SECOND: evt = sec_evt_i;
            PER_MINUTE: evt = min_evt_i;
            default:    evt = hour_evt_i;
        endcase
        st_d = st_q;
        if (evt)        st_d.pend = 1'b1;
        else if (clr_i) st_d.pend = 1'b0;
        if (quiet_i)                    st_d.pulse = 1'b0;
        else if (tick64_i && st_q.pulse) st_d.pulse = 1'b0;
        else if (evt)                   st_d.pulse = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = !mask_i && (level_i ? st_q.pend : st_q.pulse);

    // R8: a selected period event always leaves the flag set
    assert_event_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> st_q.pend);

    // R10: a pulse never survives the 64 Hz tick that ends it
    assert_pulse_one_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && tick64_i) |=> !st_q.pulse);
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter bit DEFAULT_24H = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz_i,
    input  logic             tick_64hz_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] addr_i,
    input  logic [DIG_W-1:0] wdata_i,
    output logic [DIG_W-1:0] rdata_o,
    output logic             irq_o
);
    typedef struct packed {
        rtc_time_t        tm;
        logic             hold;
        logic             tick_owed;
        logic [DIG_W-1:0] outctl;
        logic             f_rst;
        logic             f_stop;
        logic             f_h24;
        logic             f_test;
        logic             h24_live;
    } core_state_t;

    localparam rtc_time_t TIME_INIT = '{su: 4'd0, st: 4'd0, mu: 4'd0, mt: 4'd0,
                                        hu: 4'd0, ht: 4'd0, du: 4'd1, dt: 4'd0,
                                        mou: 4'd1, mot: 4'd0, yu: 4'd0, yt: 4'd0, wd: 4'd0};

    core_state_t st_q, st_d;
    rtc_time_t   adv_in, adv_out;
    logic        sec_wrap, min_wrap;
    logic        run, adj_wr, do_adv, pend_clr, pend;

    always_comb begin
        run      = !st_q.f_rst && !st_q.f_stop;
        adj_wr   = wr_en_i && (addr_i == IX_SYNC) && wdata_i[3];
        pend_clr = wr_en_i && (addr_i == IX_SYNC) && !wdata_i[2];
        do_adv   = run && !st_q.hold && (tick_1hz_i || st_q.tick_owed) && !adj_wr;
        adv_in   = st_q.tm;
        if (adj_wr) begin
            adv_in.su = 4'd9;
            adv_in.st = 4'd5;
        end
    end

    rtc_advance u_adv (
        .tm_i       (adv_in),
        .h24_i      (st_q.h24_live),
        .tm_o       (adv_out),
        .sec_wrap_o (sec_wrap),
        .min_wrap_o (min_wrap)
    );

    rtc_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick64_i   (tick_64hz_i),
        .run_i      (run),
        .sec_evt_i  (do_adv),
        .min_evt_i  (do_adv && sec_wrap),
        .hour_evt_i (do_adv && min_wrap),
        .period_i   (rtc_period_e'(st_q.outctl[3:2])),
        .level_i    (st_q.outctl[1]),
        .mask_i     (st_q.outctl[0]),
        .clr_i      (pend_clr),
        .quiet_i    (st_q.f_rst),
        .pend_o     (pend),
        .irq_o      (irq_o)
    );

    always_comb begin
        st_d = st_q;
        // rounding adjust or tick-driven advance
        if (adj_wr) begin
            if (bcd_to_bin(st_q.tm.st, st_q.tm.su) >= 8'd30) begin
                st_d.tm = adv_out;
            end else begin
                st_d.tm.su = 4'd0;
                st_d.tm.st = 4'd0;
            end
        end else if (do_adv) begin
            st_d.tm = adv_out;
        end
        // deferred tick bookkeeping
        if (!run || do_adv) st_d.tick_owed = 1'b0;
        else if (tick_1hz_i) st_d.tick_owed = 1'b1;
        // host writes overlay the computed values
        if (wr_en_i) begin
            case (addr_i)
                IX_SEC_U:  st_d.tm.su  = wdata_i;
                IX_SEC_T:  st_d.tm.st  = wdata_i;
                IX_MIN_U:  st_d.tm.mu  = wdata_i;
                IX_MIN_T:  st_d.tm.mt  = wdata_i;
                IX_HR_U:   st_d.tm.hu  = wdata_i;
                IX_HR_T:   st_d.tm.ht  = wdata_i;
                IX_DAY_U:  st_d.tm.du  = wdata_i;
                IX_DAY_T:  st_d.tm.dt  = wdata_i;
                IX_MON_U:  st_d.tm.mou = wdata_i;
                IX_MON_T:  st_d.tm.mot = wdata_i;
                IX_YR_U:   st_d.tm.yu  = wdata_i;
                IX_YR_T:   st_d.tm.yt  = wdata_i;
                IX_WDAY:   st_d.tm.wd  = wdata_i;
                IX_SYNC:   st_d.hold   = wdata_i[0];
                IX_OUTCTL: st_d.outctl = wdata_i;
                default: begin
                    st_d.f_rst  = wdata_i[0];
                    st_d.f_stop = wdata_i[1];
                    st_d.f_h24  = wdata_i[2];
                    st_d.f_test = wdata_i[3];
                end
            endcase
        end
        // seconds reset dominates everything on the seconds digits
        if (st_q.f_rst) begin
            st_d.tm.su     = 4'd0;
            st_d.tm.st     = 4'd0;
            st_d.tick_owed = 1'b0;
            st_d.h24_live  = st_q.f_h24;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tm        <= TIME_INIT;
            st_q.hold      <= 1'b0;
            st_q.tick_owed <= 1'b0;
            st_q.outctl    <= 4'b0001;
            st_q.f_rst     <= 1'b0;
            st_q.f_stop    <= 1'b0;
            st_q.f_h24     <= DEFAULT_24H;
            st_q.f_test    <= 1'b0;
            st_q.h24_live  <= DEFAULT_24H;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr_i)
            IX_SEC_U:  rdata_o = st_q.tm.su;
            IX_SEC_T:  rdata_o = st_q.tm.st;
            IX_MIN_U:  rdata_o = st_q.tm.mu;
            IX_MIN_T:  rdata_o = st_q.tm.mt;
            IX_HR_U:   rdata_o = st_q.tm.hu;
            IX_HR_T:   rdata_o = st_q.tm.ht;
            IX_DAY_U:  rdata_o = st_q.tm.du;
            IX_DAY_T:  rdata_o = st_q.tm.dt;
            IX_MON_U:  rdata_o = st_q.tm.mou;
            IX_MON_T:  rdata_o = st_q.tm.mot;
            IX_YR_U:   rdata_o = st_q.tm.yu;
            IX_YR_T:   rdata_o = st_q.tm.yt;
            IX_WDAY:   rdata_o = st_q.tm.wd;
            IX_SYNC:   rdata_o = {1'b0, pend, do_adv, st_q.hold};
            IX_OUTCTL: rdata_o = st_q.outctl;
            default:   rdata_o = {st_q.f_test, st_q.f_h24, st_q.f_stop, st_q.f_rst};
        endcase
    end

    // R6: with the freeze flag set and no host write, time stays put
    assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !wr_en_i && !st_q.f_rst) |=> $stable(st_q.tm));

    // R12: a stopped core without host writes keeps its time
    assert_stop_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.f_stop && !wr_en_i && !st_q.f_rst) |=> $stable(st_q.tm));

    // R13: the seconds reset clears both seconds digits
    assert_reset_clears_sec_R13: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.f_rst |=> (st_q.tm.su == 4'd0 && st_q.tm.st == 4'd0));
endmodule

// File: tb/tb_rtc_bcd_core.sv
module tb_rtc_bcd_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       tick_64hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [3:0] wdata = 4'd0;
    logic [3:0] rdata;
    logic       irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_bcd_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz_i(tick_1hz), .tick_64hz_i(tick_64hz),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPT = 2'd2;
    localparam int NV = 52;
    // {op, index, data}: write, read-and-compare, or one 1 Hz tick (R2/R3/R4)
    localparam logic [9:0] VEC [NV] = '{
        {OPW,4'd0,4'd8}, {OPW,4'd1,4'd5}, {OPW,4'd2,4'd9}, {OPW,4'd3,4'd5},
        {OPW,4'd4,4'd3}, {OPW,4'd5,4'd2}, {OPW,4'd6,4'd8}, {OPW,4'd7,4'd2},
        {OPW,4'd8,4'd2}, {OPW,4'd9,4'd0}, {OPW,4'd10,4'd3}, {OPW,4'd11,4'd2},
        {OPW,4'd12,4'd6},
        {OPT,4'd0,4'd0}, {OPR,4'd0,4'd9}, {OPR,4'd1,4'd5},
        {OPT,4'd0,4'd0}, {OPR,4'd0,4'd0}, {OPR,4'd1,4'd0}, {OPR,4'd2,4'd0},
        {OPR,4'd3,4'd0}, {OPR,4'd4,4'd0}, {OPR,4'd5,4'd0}, {OPR,4'd6,4'd1},
        {OPR,4'd7,4'd0}, {OPR,4'd8,4'd3}, {OPR,4'd9,4'd0}, {OPR,4'd12,4'd0},
        {OPW,4'd10,4'd4}, {OPW,4'd8,4'd2}, {OPW,4'd6,4'd8}, {OPW,4'd7,4'd2},
        {OPW,4'd4,4'd3}, {OPW,4'd5,4'd2}, {OPW,4'd2,4'd9}, {OPW,4'd3,4'd5},
        {OPW,4'd0,4'd9}, {OPW,4'd1,4'd5},
        {OPT,4'd0,4'd0}, {OPR,4'd6,4'd9}, {OPR,4'd7,4'd2}, {OPR,4'd8,4'd2},
        {OPW,4'd4,4'd3}, {OPW,4'd5,4'd2}, {OPW,4'd2,4'd9}, {OPW,4'd3,4'd5},
        {OPW,4'd0,4'd9}, {OPW,4'd1,4'd5},
        {OPT,4'd0,4'd0}, {OPR,4'd6,4'd1}, {OPR,4'd7,4'd0}, {OPR,4'd8,4'd3}
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1 chk(req, rdata, exp);
    endtask

    task automatic tick1();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic tick64();
        @(negedge clk); tick_64hz = 1'b1;
        @(negedge clk); tick_64hz = 1'b0;
    endtask

    task automatic set_clock(input logic [3:0] ht, hu, mt, mu, stn, su);
        wr(4'd5, ht); wr(4'd4, hu); wr(4'd3, mt); wr(4'd2, mu); wr(4'd1, stn); wr(4'd0, su);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 chk("R1 irq_o", {3'b0, irq}, 4'd0);
        rd(4'd0, 4'd0, "R1 sec units");  rd(4'd6, 4'd1, "R1 day units");
        rd(4'd8, 4'd1, "R1 month units"); rd(4'd12, 4'd0, "R1 weekday");
        rd(4'd13, 4'd0, "R1 sync reg");  rd(4'd14, 4'd1, "R1 output ctl");
        rd(4'd15, 4'd4, "R1 run ctl");

        // R2 R3 R4 vector walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][9:8])
                OPW: wr(VEC[i][7:4], VEC[i][3:0]);
                OPT: tick1();
                default: rd(VEC[i][7:4], VEC[i][3:0], $sformatf("R2/R3/R4 vector %0d", i));
            endcase
        end

        // R4 year and month wrap, 30-day month
        wr(4'd9, 4'd1); wr(4'd8, 4'd2); wr(4'd7, 4'd3); wr(4'd6, 4'd1);
        wr(4'd11, 4'd9); wr(4'd10, 4'd9);
        set_clock(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd10, 4'd0, "R4 year units"); rd(4'd11, 4'd0, "R4 year tens");
        rd(4'd8, 4'd1, "R4 month wrap"); rd(4'd9, 4'd0, "R4 month tens");
        rd(4'd6, 4'd1, "R4 day restart");
        wr(4'd9, 4'd0); wr(4'd8, 4'd4); wr(4'd7, 4'd3); wr(4'd6, 4'd0);
        set_clock(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd8, 4'd5, "R4 april end"); rd(4'd6, 4'd1, "R4 april day"); rd(4'd7, 4'd0, "R4 april tens");

        // R6 freeze and deferred tick
        wr(4'd1, 4'd1); wr(4'd0, 4'd0);
        wr(4'd13, 4'd1);
        tick1();
        rd(4'd0, 4'd0, "R6 frozen seconds");
        wr(4'd13, 4'd0);
        addr = 4'd13;
        #1 chk("R6 busy on release", {3'b0, rdata[1]}, 4'd1);
        rd(4'd0, 4'd1, "R6 deferred tick applied");
        rd(4'd13, 4'd0, "R6 busy cleared");

        // R7 rounding adjust
        set_clock(4'd1, 4'd0, 4'd5, 4'd9, 4'd4, 4'd5);
        wr(4'd13, 4'd8);
        rd(4'd0, 4'd0, "R7 sec cleared"); rd(4'd1, 4'd0, "R7 sec tens");
        rd(4'd2, 4'd0, "R7 min wrap"); rd(4'd3, 4'd0, "R7 min tens");
        rd(4'd4, 4'd1, "R7 hour carry"); rd(4'd13, 4'd0, "R7 bit self clears");
        wr(4'd3, 4'd1); wr(4'd2, 4'd0); wr(4'd1, 4'd2); wr(4'd0, 4'd9);
        wr(4'd13, 4'd8);
        rd(4'd1, 4'd0, "R7 low sec cleared"); rd(4'd2, 4'd0, "R7 min kept");
        rd(4'd3, 4'd1, "R7 min tens kept");

        // R12 stop
        wr(4'd0, 4'd3);
        wr(4'd15, 4'd6);
        tick1();
        rd(4'd0, 4'd3, "R12 stopped");
        wr(4'd15, 4'd4);
        rd(4'd0, 4'd3, "R12 tick discarded");
        tick1();
        rd(4'd0, 4'd4, "R12 resumed");

        // R13 seconds reset
        wr(4'd1, 4'd3); wr(4'd0, 4'd7);
        wr(4'd15, 4'd5);
        rd(4'd0, 4'd0, "R13 sec units"); rd(4'd1, 4'd0, "R13 sec tens");
        tick1();
        rd(4'd0, 4'd0, "R13 held");
        rd(4'd3, 4'd1, "R13 minutes kept");
        wr(4'd15, 4'd4);

        // R8 R9 R11 level style and pending flag
        wr(4'd14, 4'd6); wr(4'd13, 4'd0);
        tick1();
        rd(4'd13, 4'd4, "R8 pending set");
        #1 chk("R9 level follows pending", {3'b0, irq}, 4'd1);
        wr(4'd13, 4'd4);
        rd(4'd13, 4'd4, "R8 write one ignored");
        wr(4'd13, 4'd0);
        rd(4'd13, 4'd0, "R8 cleared");
        #1 chk("R9 level low", {3'b0, irq}, 4'd0);
        wr(4'd14, 4'd7);
        tick1();
        rd(4'd13, 4'd4, "R11 pending under mask");
        #1 chk("R11 masked output", {3'b0, irq}, 4'd0);
        wr(4'd14, 4'd10); wr(4'd1, 4'd5); wr(4'd0, 4'd8); wr(4'd13, 4'd0);
        tick1();
        rd(4'd13, 4'd0, "R8 no minute event");
        tick1();
        rd(4'd13, 4'd4, "R8 minute event");
        #1 chk("R9 minute level", {3'b0, irq}, 4'd1);

        // R10 pulse style
        wr(4'd14, 4'd4);
        tick64();
        #1 chk("R10 idle low", {3'b0, irq}, 4'd0);
        tick1();
        #1 chk("R10 pulse high", {3'b0, irq}, 4'd1);
        tick64();
        #1 chk("R10 pulse ended", {3'b0, irq}, 4'd0);

        // R5 12-hour mode, R13 mode latch
        wr(4'd15, 4'd1); wr(4'd15, 4'd0);
        set_clock(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd4, 4'd2, "R5 noon units"); rd(4'd5, 4'd5, "R5 noon PM");
        set_clock(4'd5, 4'd2, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd4, 4'd1, "R5 one PM units"); rd(4'd5, 4'd4, "R5 one PM tens");
        wr(4'd7, 4'd0); wr(4'd6, 4'd5);
        set_clock(4'd5, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd4, 4'd2, "R5 midnight units"); rd(4'd5, 4'd1, "R5 midnight AM");
        rd(4'd6, 4'd6, "R5 day advance");
        wr(4'd15, 4'd4);
        set_clock(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd5, 4'd5, "R13 mode not latched outside reset");
        wr(4'd15, 4'd5); wr(4'd15, 4'd4);
        set_clock(4'd1, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9);
        tick1();
        rd(4'd5, 4'd1, "R13 24h adopted tens"); rd(4'd4, 4'd2, "R13 24h adopted units");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule